// File: doc/BRIEF.md
# Transmit/Receive FIFO Pair with Block-Transfer Ready Signalling

This block holds two byte queues for a serial port. The host writes bytes into a transmit queue that the serial side drains, and the serial side fills a receive queue that the host reads. Each queue holds 32 bytes. The block also drives two active-low ready pins that an external transfer engine watches to decide when to move data.

A single mode input selects how both ready pins behave. In level mode each pin simply follows whether its queue is empty. In block mode each pin is a held flag with separate set and clear events. The receive flag drops once the queue reaches a selectable fill threshold or a time-out pulse arrives, and it rises again only when the queue drains to empty. The transmit flag rises when its queue fills and drops when exactly one slot is free. A host write into a full queue, or a read from an empty one, is dropped and latches a sticky error bit until reset.

Top module: `uart_fifo_ready`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) empties both queues: after that edge both levels read 0, both empty flags read 1, rxrdy_n reads 1, txrdy_n reads 0 and all four sticky error bits read 0.
- R2: Each queue returns bytes in the order they were accepted. The head byte is visible on the read-data port with no extra cycle. The level output counts accepted bytes from 0 to 32, the full flag is 1 at 32 and the empty flag is 1 at 0, all updated at the edge that accepts the strobe.
- R3: With dma_mode low, rxrdy_n is 1 when the receive queue is empty and 0 when it holds one byte or more, in the same cycle as the level.
- R4: With dma_mode low, txrdy_n is 0 when the transmit queue is empty and 1 when it holds one byte or more, in the same cycle as the level.
- R5: rx_trig_sel chooses the receive threshold: code 0 is 1 byte, code 1 is 8 bytes, code 2 is 16 bytes and code 3 is 28 bytes.
- R6: With dma_mode high, rxrdy_n goes to 0 one edge after the receive level is at or above the threshold, or one edge after rx_timeout is high while the queue is not empty.
- R7: With dma_mode high, once rxrdy_n is 0 it stays 0 until the receive queue is empty, and it returns to 1 one edge after the level reads 0.
- R8: With dma_mode high, txrdy_n goes to 1 one edge after the transmit level reads 32 and goes to 0 one edge after it reads 31. At any other level it holds its value.
- R9: On the first cycle with dma_mode high, each ready pin shows the value that level mode gave on the previous cycle, and block-mode events evolve it from there.
- R10: A host write to a full transmit queue or a serial push to a full receive queue is dropped, so the level and contents are unchanged, and it sets tx_ovf or rx_ovf respectively, which stay set until reset.
- R11: A serial pop from an empty transmit queue or a host read from an empty receive queue is dropped, so the level stays 0, and it sets tx_unf or rx_unf respectively, which stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dma_mode | input | 1 | 1 selects block mode for both ready pins |
| rx_trig_sel | input | 2 | Receive threshold code |
| host_wr | input | 1 | Host write strobe into the transmit queue |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe from the receive queue |
| host_rdata | output | 8 | Receive queue head byte |
| ser_pop | input | 1 | Serial side takes a byte from the transmit queue |
| ser_tdata | output | 8 | Transmit queue head byte |
| ser_push | input | 1 | Serial side delivers a byte to the receive queue |
| ser_rdata | input | 8 | Byte delivered by the serial side |
| rx_timeout | input | 1 | One-cycle receive time-out pulse |
| rxrdy_n | output | 1 | Receive ready pin |
| txrdy_n | output | 1 | Transmit ready pin |
| tx_level | output | 6 | Transmit queue fill count |
| rx_level | output | 6 | Receive queue fill count |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_unf | output | 1 | Sticky transmit underflow |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_unf | output | 1 | Sticky receive underflow |

## Verification
Levels, flags, head data and the level-mode ready pins are due at the edge that accepts a strobe. The block-mode ready pins lag them by one more edge, because their flag is sampled from the registered level. Every stimulus in the bench is driven on the falling edge and released on the next falling edge. One idle rising edge then passes, and the outputs are sampled one nanosecond later, so both latencies have settled whichever is being checked. Head data is compared on falling edges, half a cycle after the edge that moved the read pointer.

// File: rtl/uart_rdy_pkg.sv
`timescale 1ns/1ps
package uart_rdy_pkg;

  typedef enum logic {
    RDY_LEVEL = 1'b0,
    RDY_BLOCK = 1'b1
  } rdy_mode_e;

  // Ring pointer advance for an arbitrary depth.
  function automatic int unsigned wrap_inc(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

  // Fill count after one cycle of accepted push/pop.
  function automatic int unsigned level_next(input int unsigned lvl, input logic acc_push,
                                             input logic acc_pop);
    int unsigned r;
    r = lvl;
    if (acc_push && !acc_pop) r = lvl + 1;
    if (!acc_push && acc_pop) r = lvl - 1;
    return r;
  endfunction

  // Receive threshold in bytes for a 2-bit code, never above the depth.
  function automatic int unsigned trig_bytes(input logic [1:0] sel, input int unsigned depth);
    int unsigned b;
    case (sel)
      2'd0:    b = 1;
      2'd1:    b = 8;
      2'd2:    b = 16;
      default: b = 28;
    endcase
    return (b > depth) ? depth : b;
  endfunction

endpackage

// File: rtl/byte_fifo.sv
`timescale 1ns/1ps
module byte_fifo
  import uart_rdy_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             push_drop,
  output logic             pop_drop
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic             acc_push;
  logic             acc_pop;

  assign full      = (level == LVL_W'(DEPTH));
  assign empty     = (level == '0);
  assign acc_push  = push && !full;
  assign acc_pop   = pop && !empty;
  assign push_drop = push && full;
  assign pop_drop  = pop && empty;
  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (acc_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (acc_push) wr_ptr <= PTR_W'(wrap_inc(32'(wr_ptr), DEPTH));
      if (acc_pop)  rd_ptr <= PTR_W'(wrap_inc(32'(rd_ptr), DEPTH));
      level <= LVL_W'(level_next(32'(level), acc_push, acc_pop));
    end
  end

endmodule

// File: rtl/rx_rdy_ctl.sv
`timescale 1ns/1ps
module rx_rdy_ctl
  import uart_rdy_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  rdy_mode_e        mode,
  input  logic [LVL_W-1:0] level,
  input  logic             empty,
  input  logic [LVL_W-1:0] trig,
  input  logic             timeout,
  output logic             rdy_n
);

  logic held_q;
  logic evt_trig;
  logic evt_tmo;
  logic lvl_view;

  // Level view: high while empty.
  assign lvl_view = empty;
  assign evt_trig = (level >= trig);
  assign evt_tmo  = timeout && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b1;
    end else if (mode == RDY_LEVEL) begin
      held_q <= lvl_view;
    end else if (empty) begin
      held_q <= 1'b1;
    end else if (evt_trig || evt_tmo) begin
      held_q <= 1'b0;
    end
  end

  assign rdy_n = (mode == RDY_BLOCK) ? held_q : lvl_view;

endmodule

// File: rtl/tx_rdy_ctl.sv
`timescale 1ns/1ps
module tx_rdy_ctl
  import uart_rdy_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  rdy_mode_e        mode,
  input  logic [LVL_W-1:0] level,
  input  logic             empty,
  output logic             rdy_n
);

  logic held_q;
  logic evt_full;
  logic evt_one_free;
  logic lvl_view;

  // Level view: high while holding data.
  assign lvl_view     = !empty;
  assign evt_full     = (level == LVL_W'(DEPTH));
  assign evt_one_free = (level == LVL_W'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
    end else if (mode == RDY_LEVEL) begin
      held_q <= lvl_view;
    end else if (evt_full) begin
      held_q <= 1'b1;
    end else if (evt_one_free) begin
      held_q <= 1'b0;
    end
  end

  assign rdy_n = (mode == RDY_BLOCK) ? held_q : lvl_view;

endmodule

// File: rtl/uart_fifo_ready.sv
`timescale 1ns/1ps
module uart_fifo_ready
  import uart_rdy_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int N_ERR = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dma_mode,
  input  logic [1:0]       rx_trig_sel,
  input  logic             host_wr,
  input  logic [WIDTH-1:0] host_wdata,
  input  logic             host_rd,
  output logic [WIDTH-1:0] host_rdata,
  input  logic             ser_pop,
  output logic [WIDTH-1:0] ser_tdata,
  input  logic             ser_push,
  input  logic [WIDTH-1:0] ser_rdata,
  input  logic             rx_timeout,
  output logic             rxrdy_n,
  output logic             txrdy_n,
  output logic [LVL_W-1:0] tx_level,
  output logic [LVL_W-1:0] rx_level,
  output logic             tx_full,
  output logic             tx_empty,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             tx_ovf,
  output logic             tx_unf,
  output logic             rx_ovf,
  output logic             rx_unf
);

  rdy_mode_e        mode;
  logic [LVL_W-1:0] rx_trig_lvl;
  logic             tx_wr_drop;
  logic             tx_rd_drop;
  logic             rx_wr_drop;
  logic             rx_rd_drop;
  logic [N_ERR-1:0] err_evt;
  logic [N_ERR-1:0] err_q;

  assign mode        = dma_mode ? RDY_BLOCK : RDY_LEVEL;
  assign rx_trig_lvl = LVL_W'(trig_bytes(rx_trig_sel, DEPTH));

  byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_tx_q (
    .clk       (clk),
    .rst       (rst),
    .push      (host_wr),
    .push_data (host_wdata),
    .pop       (ser_pop),
    .head_data (ser_tdata),
    .level     (tx_level),
    .full      (tx_full),
    .empty     (tx_empty),
    .push_drop (tx_wr_drop),
    .pop_drop  (tx_rd_drop)
  );

  byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_rx_q (
    .clk       (clk),
    .rst       (rst),
    .push      (ser_push),
    .push_data (ser_rdata),
    .pop       (host_rd),
    .head_data (host_rdata),
    .level     (rx_level),
    .full      (rx_full),
    .empty     (rx_empty),
    .push_drop (rx_wr_drop),
    .pop_drop  (rx_rd_drop)
  );

  rx_rdy_ctl #(.DEPTH(DEPTH)) i_rx_rdy (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .level   (rx_level),
    .empty   (rx_empty),
    .trig    (rx_trig_lvl),
    .timeout (rx_timeout),
    .rdy_n   (rxrdy_n)
  );

  tx_rdy_ctl #(.DEPTH(DEPTH)) i_tx_rdy (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .level (tx_level),
    .empty (tx_empty),
    .rdy_n (txrdy_n)
  );

  // Sticky error bits: 0 tx over, 1 tx under, 2 rx over, 3 rx under.
  assign err_evt = {rx_rd_drop, rx_wr_drop, tx_rd_drop, tx_wr_drop};

  for (genvar g = 0; g < N_ERR; g++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (rst)             err_q[g] <= 1'b0;
      else if (err_evt[g]) err_q[g] <= 1'b1;
    end
  end

  assign tx_ovf = err_q[0];
  assign tx_unf = err_q[1];
  assign rx_ovf = err_q[2];
  assign rx_unf = err_q[3];

endmodule

// File: rtl/uart_fifo_ready_chk.sv
`timescale 1ns/1ps
module uart_fifo_ready_chk #(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             dma_mode,
  input logic             host_wr,
  input logic             host_rd,
  input logic             ser_push,
  input logic             ser_pop,
  input logic             rx_timeout,
  input logic             rxrdy_n,
  input logic             txrdy_n,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             tx_full,
  input logic             rx_empty,
  input logic             tx_ovf,
  input logic             rx_unf
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] ONE_FREE = LVL_W'(DEPTH - 1);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rx_level == '0 && tx_level == '0 && rxrdy_n && !txrdy_n && !tx_ovf && !rx_unf));

  // R3
  level_rx_chk: assert property (@(posedge clk) disable iff (rst)
    !dma_mode |-> (rxrdy_n == (rx_level == '0)));

  // R4
  level_tx_chk: assert property (@(posedge clk) disable iff (rst)
    !dma_mode |-> (txrdy_n == (tx_level != '0)));

  // R6
  block_rx_tmo_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_mode && $past(dma_mode) && !$past(rst) && $past(rx_timeout) && $past(rx_level) != '0)
    |-> !rxrdy_n);

  // R7
  block_rx_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_mode && $past(dma_mode) && !$past(rst) && $past(rx_level) == '0) |-> rxrdy_n);

  // R8
  block_tx_full_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_mode && $past(dma_mode) && !$past(rst) && $past(tx_level) == FULL_LVL) |-> txrdy_n);

  // R8
  block_tx_free_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_mode && $past(dma_mode) && !$past(rst) && $past(tx_level) == ONE_FREE) |-> !txrdy_n);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_full && host_wr && !ser_pop) |=> (tx_level == FULL_LVL && tx_ovf));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ovf |=> tx_ovf);

  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_empty && host_rd && !ser_push) |=> (rx_level == '0 && rx_unf));

endmodule

bind uart_fifo_ready uart_fifo_ready_chk #(.DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_uart_fifo_ready.sv
`timescale 1ns/1ps
module test_uart_fifo_ready;

  localparam int DEPTH = 32;
  localparam int LW = 6;
  localparam logic [2:0] NOP = 3'd0, HWR = 3'd1, HRD = 3'd2, SPU = 3'd3, SPO = 3'd4, TMO = 3'd5;

  typedef struct packed {
    logic [2:0] op;
    logic [5:0] n;
    logic       dma;
    logic [1:0] sel;
    logic       e_rx;
    logic       e_tx;
    logic [5:0] e_rl;
    logic [5:0] e_tl;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{NOP, 6'd0,  1'b0, 2'd1, 1'b1, 1'b0, 6'd0,  6'd0},   // R3 R4 idle
    '{HWR, 6'd1,  1'b0, 2'd1, 1'b1, 1'b1, 6'd0,  6'd1},   // R4
    '{SPO, 6'd1,  1'b0, 2'd1, 1'b1, 1'b0, 6'd0,  6'd0},   // R4
    '{SPU, 6'd3,  1'b0, 2'd1, 1'b0, 1'b0, 6'd3,  6'd0},   // R3
    '{HRD, 6'd3,  1'b0, 2'd1, 1'b1, 1'b0, 6'd0,  6'd0},   // R3
    '{NOP, 6'd0,  1'b1, 2'd1, 1'b1, 1'b0, 6'd0,  6'd0},   // R9
    '{SPU, 6'd7,  1'b1, 2'd1, 1'b1, 1'b0, 6'd7,  6'd0},   // R6 below threshold
    '{SPU, 6'd1,  1'b1, 2'd1, 1'b0, 1'b0, 6'd8,  6'd0},   // R6 R5 code 1
    '{HRD, 6'd7,  1'b1, 2'd1, 1'b0, 1'b0, 6'd1,  6'd0},   // R7 hold
    '{HRD, 6'd1,  1'b1, 2'd1, 1'b1, 1'b0, 6'd0,  6'd0},   // R7 release
    '{SPU, 6'd2,  1'b1, 2'd1, 1'b1, 1'b0, 6'd2,  6'd0},   // R6
    '{TMO, 6'd1,  1'b1, 2'd1, 1'b0, 1'b0, 6'd2,  6'd0},   // R6 time-out
    '{HRD, 6'd2,  1'b1, 2'd1, 1'b1, 1'b0, 6'd0,  6'd0},   // R7
    '{HWR, 6'd31, 1'b1, 2'd1, 1'b1, 1'b0, 6'd0,  6'd31},  // R8
    '{HWR, 6'd1,  1'b1, 2'd1, 1'b1, 1'b1, 6'd0,  6'd32},  // R8 full
    '{SPO, 6'd1,  1'b1, 2'd1, 1'b1, 1'b0, 6'd0,  6'd31},  // R8 one free
    '{SPO, 6'd30, 1'b1, 2'd1, 1'b1, 1'b0, 6'd0,  6'd1},   // R8
    '{HWR, 6'd31, 1'b1, 2'd1, 1'b1, 1'b1, 6'd0,  6'd32},  // R8
    '{SPO, 6'd32, 1'b1, 2'd1, 1'b1, 1'b0, 6'd0,  6'd0},   // R8
    '{NOP, 6'd0,  1'b1, 2'd0, 1'b1, 1'b0, 6'd0,  6'd0},   // R5
    '{SPU, 6'd1,  1'b1, 2'd0, 1'b0, 1'b0, 6'd1,  6'd0},   // R5 code 0
    '{HRD, 6'd1,  1'b1, 2'd0, 1'b1, 1'b0, 6'd0,  6'd0},   // R7
    '{SPU, 6'd15, 1'b1, 2'd2, 1'b1, 1'b0, 6'd15, 6'd0},   // R5 code 2
    '{SPU, 6'd1,  1'b1, 2'd2, 1'b0, 1'b0, 6'd16, 6'd0},   // R5
    '{HRD, 6'd16, 1'b1, 2'd2, 1'b1, 1'b0, 6'd0,  6'd0},   // R7
    '{SPU, 6'd27, 1'b1, 2'd3, 1'b1, 1'b0, 6'd27, 6'd0},   // R5 code 3
    '{SPU, 6'd1,  1'b1, 2'd3, 1'b0, 1'b0, 6'd28, 6'd0},   // R5
    '{NOP, 6'd0,  1'b0, 2'd3, 1'b0, 1'b0, 6'd28, 6'd0},   // R3 back to level
    '{HRD, 6'd28, 1'b0, 2'd3, 1'b1, 1'b0, 6'd0,  6'd0},   // R3
    '{HWR, 6'd5,  1'b0, 2'd3, 1'b1, 1'b1, 6'd0,  6'd5},   // R4
    '{NOP, 6'd0,  1'b1, 2'd3, 1'b1, 1'b1, 6'd0,  6'd5},   // R9 load 1
    '{SPO, 6'd5,  1'b1, 2'd3, 1'b1, 1'b1, 6'd0,  6'd0},   // R8 hold
    '{NOP, 6'd0,  1'b0, 2'd3, 1'b1, 1'b0, 6'd0,  6'd0}    // R4
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dma_mode = 1'b0;
  logic [1:0]    rx_trig_sel = 2'd1;
  logic          host_wr = 1'b0;
  logic [7:0]    host_wdata = 8'h00;
  logic          host_rd = 1'b0;
  logic [7:0]    host_rdata;
  logic          ser_pop = 1'b0;
  logic [7:0]    ser_tdata;
  logic          ser_push = 1'b0;
  logic [7:0]    ser_rdata = 8'h00;
  logic          rx_timeout = 1'b0;
  logic          rxrdy_n, txrdy_n;
  logic [LW-1:0] tx_level, rx_level;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_ovf, tx_unf, rx_ovf, rx_unf;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_fifo_ready i_uart_fifo_ready (
    .clk(clk), .rst(rst), .dma_mode(dma_mode), .rx_trig_sel(rx_trig_sel),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .ser_pop(ser_pop), .ser_tdata(ser_tdata), .ser_push(ser_push), .ser_rdata(ser_rdata),
    .rx_timeout(rx_timeout), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n),
    .tx_level(tx_level), .rx_level(rx_level), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_empty(rx_empty), .tx_ovf(tx_ovf), .tx_unf(tx_unf),
    .rx_ovf(rx_ovf), .rx_unf(rx_unf)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic release_strobes();
    host_wr = 1'b0; host_rd = 1'b0; ser_pop = 1'b0; ser_push = 1'b0; rx_timeout = 1'b0;
  endtask

  // Drive op for n cycles, release, let one idle rising edge pass, then sample.
  task automatic run_op(input logic [2:0] op, input int n, input logic dma, input logic [1:0] sel,
                        input logic [7:0] base);
    @(negedge clk);
    dma_mode = dma;
    rx_trig_sel = sel;
    for (int i = 0; i < n; i++) begin
      case (op)
        HWR: begin host_wr = 1'b1; host_wdata = base + 8'(i); end
        HRD: host_rd = 1'b1;
        SPU: begin ser_push = 1'b1; ser_rdata = base + 8'(i); end
        SPO: ser_pop = 1'b1;
        TMO: rx_timeout = 1'b1;
        default: ;
      endcase
      @(negedge clk);
      release_strobes();
    end
    @(posedge clk);
    #1;
  endtask

  task automatic reset_pulse();
    @(negedge clk);
    rst = 1'b1;
    release_strobes();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " rx_level"}, int'(rx_level), 0);
    chk({tag, " tx_level"}, int'(tx_level), 0);
    chk({tag, " empties"}, int'({rx_empty, tx_empty}), 3);
    chk({tag, " rxrdy_n"}, int'(rxrdy_n), 1);
    chk({tag, " txrdy_n"}, int'(txrdy_n), 0);
    chk({tag, " sticky"}, int'({tx_ovf, tx_unf, rx_ovf, rx_unf}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    reset_pulse();
    check_idle("R1 power-up");

    // Table walk: R3..R9 over level and block modes.
    for (int v = 0; v < NV; v++) begin
      run_op(VECS[v].op, int'(VECS[v].n), VECS[v].dma, VECS[v].sel, 8'h10);
      chk($sformatf("R3/R6/R7 vec%0d rxrdy_n", v), int'(rxrdy_n), int'(VECS[v].e_rx));
      chk($sformatf("R4/R8/R9 vec%0d txrdy_n", v), int'(txrdy_n), int'(VECS[v].e_tx));
      chk($sformatf("R2 vec%0d rx_level", v), int'(rx_level), int'(VECS[v].e_rl));
      chk($sformatf("R2 vec%0d tx_level", v), int'(tx_level), int'(VECS[v].e_tl));
    end

    // R10 transmit overflow, then R2 ordering on drain, then R11 underflow.
    reset_pulse();
    run_op(HWR, DEPTH + 1, 1'b0, 2'd1, 8'h40);
    chk("R10 tx_level after extra write", int'(tx_level), DEPTH);
    chk("R2 tx_full", int'(tx_full), 1);
    chk("R10 tx_ovf", int'(tx_ovf), 1);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      chk($sformatf("R2 tx byte %0d", i), int'(ser_tdata), int'(8'h40 + 8'(i)));
      ser_pop = 1'b1;
    end
    @(negedge clk);
    ser_pop = 1'b0;
    chk("R2 tx_empty after drain", int'(tx_empty), 1);
    chk("R10 tx_ovf still set", int'(tx_ovf), 1);
    chk("R11 tx_unf clear before", int'(tx_unf), 0);
    run_op(SPO, 1, 1'b0, 2'd1, 8'h00);
    chk("R11 tx_level after empty pop", int'(tx_level), 0);
    chk("R11 tx_unf", int'(tx_unf), 1);

    // R10 receive overflow, R2 ordering, R11 receive underflow.
    run_op(SPU, DEPTH + 1, 1'b0, 2'd1, 8'hC0);
    chk("R10 rx_level after extra push", int'(rx_level), DEPTH);
    chk("R2 rx_full", int'(rx_full), 1);
    chk("R10 rx_ovf", int'(rx_ovf), 1);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      chk($sformatf("R2 rx byte %0d", i), int'(host_rdata), int'(8'hC0 + 8'(i)));
      host_rd = 1'b1;
    end
    @(negedge clk);
    host_rd = 1'b0;
    chk("R11 rx_unf clear before", int'(rx_unf), 0);
    run_op(HRD, 1, 1'b0, 2'd1, 8'h00);
    chk("R11 rx_level after empty read", int'(rx_level), 0);
    chk("R11 rx_unf", int'(rx_unf), 1);
    chk("R11 rx_empty", int'(rx_empty), 1);

    // R1 reset from a busy state in block mode.
    run_op(HWR, DEPTH, 1'b1, 2'd0, 8'h70);
    run_op(SPU, 4, 1'b1, 2'd0, 8'h80);
    chk("R8 txrdy_n before reset", int'(txrdy_n), 1);
    chk("R6 rxrdy_n before reset", int'(rxrdy_n), 0);
    reset_pulse();
    check_idle("R1 busy reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule